// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a synthesizable model of a 512-byte serial EEPROM. It acts as a target on an I2C bus. The storage is split into two 256-byte blocks. The block samples SCL and SDA with its own system clock and finds START and STOP conditions. It checks the device select byte against a fixed type code and two strap inputs, and it acknowledges each byte it accepts. It pulls SDA low through an open-drain enable to send acknowledges and read data.

Written bytes collect in an 8-entry latch buffer. The buffer is committed to the array only when a STOP ends the write. The commit runs as a busy period of a set number of clock cycles, and during that period the block ignores the bus entirely. A bus master finds the end of the busy period by sending select bytes until one is acknowledged.

A mode input chooses how the write address advances. In page mode it wraps inside an 8-byte row. In multibyte mode it runs freely and accepts at most four bytes. Reads come from a 9-bit address counter. A protect input and a guard byte at the top of memory together lock an upper part of the second block against writes.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The select byte is received MSB first. Bits 7:4 must be 1010 and bits 3:2 must equal `chip_sel_i`. Bit 1 picks the block (address bit 8) and bit 0 is the direction (1 = read). A select byte that does not match gets no acknowledge, and the block then ignores every bit until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point, including partway through a byte, restarts reception of a select byte.
- R3: For each accepted byte, the block pulls SDA low during the 9th SCL clock. It changes its SDA drive only while SCL is low. After reset it does not drive SDA.
- R4: A write sequence is START, select with bit 0 = 0, address byte, data, STOP. After the busy period that follows, the data is stored at the address given by the block bit and the address byte.
- R5: With `wr_mode_i` low (page mode), only address bits 2:0 advance after each data byte. Bytes past the end of an 8-byte row wrap to the start of that row, and a later byte replaces an earlier one at the same location.
- R6: With `wr_mode_i` high (multibyte mode), data bytes go to consecutive addresses inside the block, starting at any address. Only the first four bytes are stored. Any later bytes are acknowledged and discarded.
- R7: A STOP that ends a write holding at least one data byte starts a busy period of `BUSY_CYC` clock cycles. During this period the block drives nothing and acknowledges nothing. After it ends, a select byte is acknowledged again.
- R8: A random read is a dummy write that sets the address, then a repeated START with a read select. A read select with no address byte before it returns the byte at the current counter. The counter advances after every byte that is sent.
- R9: The block keeps sending bytes from consecutive addresses while the master acknowledges. The 9-bit counter wraps from 0x1FF to 0x000.
- R10: When the master does not acknowledge a read byte, the block releases SDA. It then stays silent until the next START.
- R11: When `prot_en_i` is high and bit 2 of the byte at 0x1FF is 0, writes are discarded for every address from {1, bits 7:3 of that byte, 000} up to 0x1FF inclusive. Both the guard byte and `prot_en_i` are taken at the STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | When high, pulls SDA low (open drain) |
| chip_sel_i | input | 2 | Strap value compared with select bits 3:2 |
| wr_mode_i | input | 1 | 1 = multibyte write, 0 = page write |
| prot_en_i | input | 1 | Enables the guard-byte write lock |

## Verification
Select bytes are tried with a wrong type code, a wrong strap value, a missing START and a START that cuts a byte in half. These cases separate address decode from START detection. Writes are tried in page mode starting near the end of a row and with nine bytes, and in multibyte mode with five bytes that cross a row. Reading each region back shows the difference between row wrap, free increment and the four-byte limit. Reads cover random, current-address and sequential access across 0x1FF. A NACK followed by clocks with no START checks that the block falls silent. Protection is checked below and above the boundary, on the guard byte itself, with the lock input off, and with the guard's disable bit set.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int AW     = 9;
  localparam int DW     = 8;
  localparam int ROW_W  = 3;
  localparam int MEM_B  = 1 << AW;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_ADDR, S_WR, S_RD} bus_st_t;

  // Address after a stored data byte: row wrap in page mode, block wrap otherwise.
  function automatic logic [AW-1:0] wr_step(input logic [AW-1:0] a, input logic page);
    if (page) return {a[AW-1:ROW_W], a[ROW_W-1:0] + ROW_W'(1)};
    return {a[AW-1], a[AW-2:0] + (AW-1)'(1)};
  endfunction

  // Write lock: enabled input, guard flag cleared, upper block, at or above boundary row.
  function automatic logic is_locked(input logic [AW-1:0] a, input logic [DW-1:0] guard,
                                     input logic pre_on);
    return pre_on && !guard[2] && a[AW-1] && (a[AW-2:ROW_W] >= guard[DW-1:ROW_W]);
  endfunction
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_h,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_sh[SYNC-1];
      sda_q  <= sda_sh[SYNC-1];
    end
  end

  assign scl_h    = scl_sh[SYNC-1];
  assign sda_s    = sda_sh[SYNC-1];
  assign ev_rise  = scl_h && !scl_q;
  assign ev_fall  = !scl_h && scl_q;
  assign ev_start = scl_h && scl_q && sda_q && !sda_s;
  assign ev_stop  = scl_h && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array
  import eeprom_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] guard
);
  logic [DW-1:0] cells [MEM_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_B; i++) cells[i] <= '1;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
  assign guard = cells[MEM_B-1];
endmodule

// File: rtl/eeprom_write_buffer.sv
module eeprom_write_buffer
  import eeprom_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int BUSY_CYC  = 64,
  parameter int MULTI_MAX = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          page_mode,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          commit,
  input  logic [DW-1:0] guard_i,
  input  logic          pre_i,
  output logic          busy_o,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [DEPTH-1:0] valid;
  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [IW:0]      fill;
  logic [CW-1:0]    bcnt;
  logic [DW-1:0]    guard_q;
  logic             pre_q;
  logic [IW-1:0]    slot, cidx;
  logic             room, in_window;

  assign slot      = page_mode ? push_addr[IW-1:0] : fill[IW-1:0];
  assign room      = page_mode || (int'(fill) < MULTI_MAX);
  assign cidx      = bcnt[IW-1:0];
  assign in_window = int'(bcnt) < DEPTH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= '0;
      fill    <= '0;
      bcnt    <= '0;
      busy_o  <= 1'b0;
      guard_q <= '0;
      pre_q   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= '0;
        e_data[i] <= '0;
      end
    end else if (busy_o) begin
      bcnt <= bcnt + CW'(1);
      if (int'(bcnt) == BUSY_CYC - 1) begin
        busy_o <= 1'b0;
        valid  <= '0;
        fill   <= '0;
      end
    end else if (clear) begin
      valid <= '0;
      fill  <= '0;
    end else if (push && room) begin
      valid[slot]  <= 1'b1;
      e_addr[slot] <= push_addr;
      e_data[slot] <= push_data;
      if (!page_mode) fill <= fill + (IW+1)'(1);
    end else if (commit && |valid) begin
      busy_o  <= 1'b1;
      bcnt    <= '0;
      guard_q <= guard_i;
      pre_q   <= pre_i;
    end
  end

  assign mem_we    = busy_o && in_window && valid[cidx] && !is_locked(e_addr[cidx], guard_q, pre_q);
  assign mem_waddr = e_addr[cidx];
  assign mem_wdata = e_data[cidx];

  // R7: the bus side never hands over a byte while the commit is running
  p_no_push_busy_r7: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> !push);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int BUSY_CYC    = 64,
  parameter int MULTI_MAX   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] chip_sel_i,
  input  logic       wr_mode_i,
  input  logic       prot_en_i
);
  localparam int ROW_BYTES = 1 << ROW_W;

  logic scl_h, sda_s, ev_rise, ev_fall, ev_start, ev_stop;
  bus_st_t st, nxt_q;
  logic [3:0]    bit_cnt;
  logic [DW-1:0] shreg, tx_q, byte_w, rdata, guard, mem_wdata;
  logic [AW-1:0] addr_q, mem_waddr;
  logic          pull_q, ack_q, busy, mem_we;
  logic          byte_done, sel_match, push, wclr, commit, page_mode;
  logic [2:0]    tx_idx;

  i2c_line_events #(.SYNC(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_h(scl_h), .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  eeprom_cell_array u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr_q), .rdata(rdata), .guard(guard)
  );

  assign page_mode = !wr_mode_i;
  assign byte_w    = {shreg[DW-2:0], sda_s};
  assign byte_done = ev_rise && bit_cnt == 4'd7 && st != S_RD && st != S_IDLE && !busy;
  assign sel_match = byte_w[7:4] == TYPE_CODE && byte_w[3:2] == chip_sel_i;
  assign push      = byte_done && st == S_WR;
  assign wclr      = byte_done && st == S_SEL && sel_match;
  assign commit    = ev_stop && st == S_WR && !busy;
  assign tx_idx    = 3'd7 - bit_cnt[2:0];

  eeprom_write_buffer #(.DEPTH(ROW_BYTES), .BUSY_CYC(BUSY_CYC), .MULTI_MAX(MULTI_MAX)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .clear(wclr), .push(push), .page_mode(page_mode),
    .push_addr(addr_q), .push_data(byte_w), .commit(commit), .guard_i(guard),
    .pre_i(prot_en_i), .busy_o(busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      nxt_q   <= S_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      addr_q  <= '0;
      pull_q  <= 1'b0;
      ack_q   <= 1'b0;
      tx_q    <= '0;
    end else if (busy) begin
      st      <= S_IDLE;
      bit_cnt <= '0;
      pull_q  <= 1'b0;
    end else if (ev_start) begin
      st      <= S_SEL;
      bit_cnt <= '0;
      pull_q  <= 1'b0;
    end else if (ev_stop) begin
      st      <= S_IDLE;
      bit_cnt <= '0;
      pull_q  <= 1'b0;
    end else if (st != S_IDLE) begin
      if (ev_rise) begin
        bit_cnt <= bit_cnt + 4'd1;
        if (st != S_RD && bit_cnt < 4'd8) shreg <= byte_w;
        if (byte_done) begin
          unique case (st)
            S_SEL: begin
              if (sel_match) begin
                ack_q        <= 1'b1;
                addr_q[AW-1] <= byte_w[1];
                nxt_q        <= byte_w[0] ? S_RD : S_ADDR;
              end else begin
                ack_q <= 1'b0;
                st    <= S_IDLE;
              end
            end
            S_ADDR: begin
              addr_q[AW-2:0] <= byte_w;
              ack_q          <= 1'b1;
              nxt_q          <= S_WR;
            end
            S_WR: begin
              addr_q <= wr_step(addr_q, page_mode);
              ack_q  <= 1'b1;
              nxt_q  <= S_WR;
            end
            default: ;
          endcase
        end
        if (st == S_RD && bit_cnt == 4'd8) begin
          addr_q <= addr_q + AW'(1);
          if (sda_s) st <= S_IDLE;
        end
      end else if (ev_fall) begin
        if (st == S_RD) begin
          if (bit_cnt == 4'd8) pull_q <= 1'b0;
          else if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            tx_q    <= rdata;
            pull_q  <= !rdata[7];
          end else if (bit_cnt != 4'd0) pull_q <= !tx_q[tx_idx];
        end else begin
          if (bit_cnt == 4'd8) pull_q <= ack_q;
          else if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            st      <= nxt_q;
            if (nxt_q == S_RD) begin
              tx_q   <= rdata;
              pull_q <= !rdata[7];
            end else pull_q <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_pull_o = pull_q;

  // R7: silent while committing
  p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_pull_o);
  // R3: drive changes only while SCL is low
  p_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_h && $past(scl_h)) |-> $stable(sda_pull_o));
  // R2: a START restarts select reception with the line released
  p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !busy) |=> (st == S_SEL && bit_cnt == 4'd0 && !sda_pull_o));
  // R10: master NACK on a read byte ends the transfer
  p_nack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && ev_rise && bit_cnt == 4'd8 && sda_s && !busy) |=> (st == S_IDLE && !sda_pull_o));
endmodule

// File: tb/sim_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_slave;
  localparam int Q = 5;
  localparam int BUSY = 600;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic mode = 1'b0, pre = 1'b0;
  logic pull, sda_line;
  int n_chk = 0, n_bad = 0;
  logic [7:0] wd [16];
  logic [7:0] exp_v [$];
  string exp_t [$];
  logic [7:0] rd_val;
  event rd_ev;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~pull;

  eeprom_i2c_slave #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(pull),
    .chip_sel_i(strap), .wr_mode_i(mode), .prot_en_i(pre)
  );

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic s);
    tick(Q); sda_m = b; tick(Q); scl = 1'b1; tick(Q); s = sda_line; tick(Q); scl = 1'b0;
  endtask

  task automatic i2c_start;
    tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic i2c_stop;
    tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); v[i] = s; end
    bit_io(nack, s);
    rd_val = v;
    ->rd_ev;
  endtask

  function automatic logic [7:0] sel(input logic blk, input logic rw);
    return {4'b1010, strap, blk, rw};
  endfunction

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_v.push_back(v); exp_t.push_back(tag);
  endtask

  task automatic wait_ready(output int tries);
    logic ack;
    tries = 0;
    do begin
      i2c_start; send_byte(sel(1'b0, 1'b0), ack); i2c_stop; tries++;
    end while (!ack && tries < 40);
  endtask

  task automatic write_bytes(input logic blk, input logic [7:0] a, input int n, input string tag, output int tries);
    logic ack;
    i2c_start;
    send_byte(sel(blk, 1'b0), ack); check(ack, "R3", {tag, " select ack"}, ack, 1);
    send_byte(a, ack);              check(ack, "R3", {tag, " address ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wd[k], ack);        check(ack, "R3", {tag, " data ack"}, ack, 1);
    end
    i2c_stop;
    wait_ready(tries);
  endtask

  task automatic read_seq(input logic blk, input logic [7:0] a, input int n, input bit do_stop);
    logic ack; logic [7:0] v;
    i2c_start;
    send_byte(sel(blk, 1'b0), ack); check(ack, "R8", "dummy write select ack", ack, 1);
    send_byte(a, ack);              check(ack, "R8", "dummy write address ack", ack, 1);
    i2c_start;
    send_byte(sel(blk, 1'b1), ack); check(ack, "R8", "read select ack", ack, 1);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, v);
    if (do_stop) i2c_stop;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rd_ev);
      if (exp_v.size() == 0) check(1'b0, "R8", "unexpected read byte", rd_val, 0);
      else begin
        logic [7:0] e; string t;
        e = exp_v.pop_front(); t = exp_t.pop_front();
        check(rd_val == e, t, "read data", rd_val, e);
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    logic ack, s; logic [7:0] v; int tries;
    tick(5); rst_n = 1'b1; tick(5);
    check(pull == 1'b0, "R3", "reset drive", pull, 0);

    // R1: wrong type code, then no START
    i2c_start;
    send_byte(8'b1011_1000, ack); check(!ack, "R1", "wrong type code nack", ack, 0);
    send_byte(sel(1'b0, 1'b0), ack); check(!ack, "R1", "no ack without START", ack, 0);
    i2c_stop;
    // R1: wrong strap
    i2c_start;
    send_byte(8'b1010_0100, ack); check(!ack, "R1", "wrong strap nack", ack, 0);
    i2c_stop;

    // R2: START cutting a byte restarts select
    i2c_start;
    bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
    i2c_start;
    send_byte(sel(1'b0, 1'b0), ack); check(ack, "R2", "select after repeated START", ack, 1);
    i2c_stop;

    // R4 + R7: byte write, first poll rejected
    wd[0] = 8'hA5;
    write_bytes(1'b0, 8'h10, 1, "R4", tries);
    check(tries > 1, "R7", "poll nacked while busy", tries, 2);
    check(tries < 40, "R7", "ack after busy", tries, 39);
    expect_byte(8'hA5, "R4");
    read_seq(1'b0, 8'h10, 1, 1'b1);

    // R5: page write across row end
    mode = 1'b0;
    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44;
    write_bytes(1'b0, 8'h1E, 4, "R5", tries);
    expect_byte(8'h33, "R5"); expect_byte(8'h44, "R5");
    for (int k = 0; k < 4; k++) expect_byte(8'hFF, "R5");
    expect_byte(8'h11, "R5"); expect_byte(8'h22, "R5");
    read_seq(1'b0, 8'h18, 8, 1'b1);
    // R5: nine bytes overwrite the first
    for (int k = 0; k < 9; k++) wd[k] = 8'(k + 1);
    write_bytes(1'b0, 8'h28, 9, "R5", tries);
    expect_byte(8'h09, "R5"); expect_byte(8'h02, "R5");
    read_seq(1'b0, 8'h28, 2, 1'b1);

    // R6: multibyte, five bytes
    mode = 1'b1;
    wd[0] = 8'hA1; wd[1] = 8'hA2; wd[2] = 8'hA3; wd[3] = 8'hA4; wd[4] = 8'hA5;
    write_bytes(1'b0, 8'h3E, 5, "R6", tries);
    expect_byte(8'hA1, "R6"); expect_byte(8'hA2, "R6"); expect_byte(8'hA3, "R6");
    expect_byte(8'hA4, "R6"); expect_byte(8'hFF, "R6");
    read_seq(1'b0, 8'h3E, 5, 1'b1);
    mode = 1'b0;

    // R8: current address read after a random read
    expect_byte(8'hA1, "R8");
    read_seq(1'b0, 8'h3E, 1, 1'b1);
    i2c_start;
    send_byte(sel(1'b0, 1'b1), ack); check(ack, "R8", "current read select ack", ack, 1);
    expect_byte(8'hA2, "R8");
    recv_byte(1'b1, v);
    i2c_stop;

    // R1: block bit selects address bit 8
    wd[0] = 8'h5A;
    write_bytes(1'b1, 8'h05, 1, "R1", tries);
    expect_byte(8'hFF, "R1"); read_seq(1'b0, 8'h05, 1, 1'b1);
    expect_byte(8'h5A, "R1"); read_seq(1'b1, 8'h05, 1, 1'b1);

    // R9: sequential read rolls from 0x1FF to 0x000
    wd[0] = 8'h77;
    write_bytes(1'b0, 8'h00, 1, "R9", tries);
    expect_byte(8'hFF, "R9"); expect_byte(8'h77, "R9");
    read_seq(1'b1, 8'hFF, 2, 1'b1);

    // R10: after NACK the line stays released without a START
    expect_byte(8'hA5, "R10");
    read_seq(1'b0, 8'h10, 1, 1'b0);
    begin
      bit ok; ok = 1'b1;
      for (int k = 0; k < 9; k++) begin bit_io(1'b1, s); if (!s) ok = 1'b0; end
      check(ok, "R10", "line released after NACK", ok, 1);
    end
    i2c_stop;

    // R11: boundary lock
    wd[0] = 8'hF0; write_bytes(1'b1, 8'hFF, 1, "R11", tries);
    pre = 1'b1;
    wd[0] = 8'h12; write_bytes(1'b1, 8'hF8, 1, "R11", tries);
    expect_byte(8'hFF, "R11"); read_seq(1'b1, 8'hF8, 1, 1'b1);
    wd[0] = 8'h34; write_bytes(1'b1, 8'hE8, 1, "R11", tries);
    expect_byte(8'h34, "R11"); read_seq(1'b1, 8'hE8, 1, 1'b1);
    wd[0] = 8'h00; write_bytes(1'b1, 8'hFF, 1, "R11", tries);
    expect_byte(8'hF0, "R11"); read_seq(1'b1, 8'hFF, 1, 1'b1);
    pre = 1'b0;
    wd[0] = 8'h12; write_bytes(1'b1, 8'hF8, 1, "R11", tries);
    expect_byte(8'h12, "R11"); read_seq(1'b1, 8'hF8, 1, 1'b1);
    wd[0] = 8'hF4; write_bytes(1'b1, 8'hFF, 1, "R11", tries);
    pre = 1'b1;
    wd[0] = 8'h56; write_bytes(1'b1, 8'hF9, 1, "R11", tries);
    expect_byte(8'h56, "R11"); read_seq(1'b1, 8'hF9, 1, 1'b1);

    tick(50);
    check(exp_v.size() == 0, "R8", "all expected bytes seen", exp_v.size(), 0);
    finish_run;
  end
endmodule